// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A bank of general-purpose I/O pins (24 by default) under a simple register bus. Each pin is an input or an output, selected by a direction register. Output data can be written whole, or changed bit by bit through three write-only registers: set, clear and toggle. Each of these changes only the bits written as 1, so software needs no read-modify-write sequence. A polarity register inverts how each pin's input is sensed.

Pin inputs pass through a two-flop synchronizer. The polarity inversion is then applied, and edges are detected on the result. Rising and falling edges each have their own per-pin enable. When an enabled edge arrives, the pin's interrupt status bit is latched. An edge status bit records which kind of edge it was. The interrupt output is the OR of all status bits, and software clears status bits by writing 1 to them.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads 0, pin_o and pin_oe_o are 0 and irq_o is 0.
- R2: A write to offset 0x20 loads the output data, which drives pin_o. A write to offset 0x24 loads the direction, which drives pin_oe_o (1 = output).
- R3: A write to offset 0x2C sets the data bits written as 1 and leaves the others unchanged. Reads of 0x2C, 0x30 and 0x34 return 0.
- R4: A write to offset 0x30 clears the data bits written as 1 and leaves the others unchanged.
- R5: A write to offset 0x34 inverts the data bits written as 1 and leaves the others unchanged.
- R6: A read of 0x20 returns, for each pin, the output data if it is an output, and otherwise the synchronized input XOR the polarity bit (polarity at offset 0x28).
- R7: With the pin's rising enable set (offset 0x08), a 0-to-1 change of the sensed input sets its status bit (offset 0x00) and its edge bit (offset 0x04) to 1, and irq_o rises no later than 3 clocks after the pin changes.
- R8: With the pin's falling enable set (offset 0x0C), a 1-to-0 change of the sensed input sets its status bit and writes 0 to its edge bit.
- R9: An edge whose direction is not enabled for that pin leaves the status bits, the edge bits and irq_o unchanged.
- R10: Edges are detected on the input after polarity inversion. With polarity set, a falling pin counts as a rising edge.
- R11: Writing to offset 0x00 clears the status bits written as 1 and keeps those written as 0. irq_o is 1 exactly when any status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | N | Write data |
| bus_rdata_o | output | N | Read data for bus_addr_i (combinational) |
| pin_i | input | N | Pin input levels |
| pin_o | output | N | Pin output levels |
| pin_oe_o | output | N | Pin output enables |
| irq_o | output | 1 | Interrupt, OR of status bits |

## Verification
The bench checks that set, clear and toggle touch only the bits written as 1. A design that let zero bits through would corrupt the neighbouring outputs.

It checks that the edge status bit is overwritten when a later edge of the opposite kind arrives on the same pin. A design that only ORed that bit in would report a stale rising edge.

Polarity is checked by driving a falling pin with the rising enable set. A design that detected edges before the inversion would stay silent there.

A disabled edge direction must raise no interrupt. Writing 0 to a status bit must not clear it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int AW = 8;
  localparam logic [AW-1:0] OFF_IRQ  = 8'h00;
  localparam logic [AW-1:0] OFF_EDGE = 8'h04;
  localparam logic [AW-1:0] OFF_RISE = 8'h08;
  localparam logic [AW-1:0] OFF_FALL = 8'h0C;
  localparam logic [AW-1:0] OFF_DATA = 8'h20;
  localparam logic [AW-1:0] OFF_DIR  = 8'h24;
  localparam logic [AW-1:0] OFF_POL  = 8'h28;
  localparam logic [AW-1:0] OFF_SET  = 8'h2C;
  localparam logic [AW-1:0] OFF_CLR  = 8'h30;
  localparam logic [AW-1:0] OFF_TOG  = 8'h34;

  typedef enum logic [3:0] {
    OP_NONE, OP_IRQ, OP_RISE, OP_FALL, OP_DATA,
    OP_DIR, OP_POL, OP_SET, OP_CLR, OP_TOG
  } wr_op_e;

  function automatic wr_op_e decode_wr(input logic we, input logic [AW-1:0] a);
    if (!we) return OP_NONE;
    case (a)
      OFF_IRQ:  return OP_IRQ;
      OFF_RISE: return OP_RISE;
      OFF_FALL: return OP_FALL;
      OFF_DATA: return OP_DATA;
      OFF_DIR:  return OP_DIR;
      OFF_POL:  return OP_POL;
      OFF_SET:  return OP_SET;
      OFF_CLR:  return OP_CLR;
      OFF_TOG:  return OP_TOG;
      default:  return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int N = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  wr_op_e       op_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] data_o,
  output logic [N-1:0] dir_o,
  output logic [N-1:0] pol_o,
  output logic [N-1:0] rise_en_o,
  output logic [N-1:0] fall_en_o
);
  logic [N-1:0] data_q, dir_q, pol_q, rise_q, fall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      case (op_i)
        OP_DATA: data_q <= wdata_i;
        OP_SET:  data_q <= data_q | wdata_i;
        OP_CLR:  data_q <= data_q & ~wdata_i;
        OP_TOG:  data_q <= data_q ^ wdata_i;
        OP_DIR:  dir_q  <= wdata_i;
        OP_POL:  pol_q  <= wdata_i;
        OP_RISE: rise_q <= wdata_i;
        OP_FALL: fall_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign data_o    = data_q;
  assign dir_o     = dir_q;
  assign pol_o     = pol_q;
  assign rise_en_o = rise_q;
  assign fall_en_o = fall_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int N = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sensed_i,
  input  logic [N-1:0] rise_en_i,
  input  logic [N-1:0] fall_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] edge_o
);
  for (genvar g = 0; g < N; g++) begin : g_pin
    logic prev_q, stat_q, kind_q;
    logic rise, fall, hit;

    assign rise = sensed_i[g] & ~prev_q;
    assign fall = ~sensed_i[g] & prev_q;
    assign hit  = (rise & rise_en_i[g]) | (fall & fall_en_i[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        stat_q <= 1'b0;
        kind_q <= 1'b0;
      end else begin
        prev_q <= sensed_i[g];
        // a new edge outranks a same-cycle clear
        stat_q <= (stat_q & ~clr_i[g]) | hit;
        if (hit) kind_q <= rise;
      end
    end

    assign status_o[g] = stat_q;
    assign edge_o[g]   = kind_q;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int N = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bus_we_i,
  input  logic [7:0]   bus_addr_i,
  input  logic [N-1:0] bus_wdata_i,
  output logic [N-1:0] bus_rdata_o,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] pin_o,
  output logic [N-1:0] pin_oe_o,
  output logic         irq_o
);
  wr_op_e       op;
  logic [N-1:0] data_q, dir_q, pol_q, rise_en, fall_en;
  logic [N-1:0] sync_in, sensed, status, edge_kind, clr_mask;

  assign op       = decode_wr(bus_we_i, bus_addr_i);
  assign clr_mask = (op == OP_IRQ) ? bus_wdata_i : '0;

  gpio_sync #(.N(N), .STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_in)
  );

  gpio_cfg_regs #(.N(N)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .wdata_i(bus_wdata_i),
    .data_o(data_q), .dir_o(dir_q), .pol_o(pol_q),
    .rise_en_o(rise_en), .fall_en_o(fall_en)
  );

  assign sensed = sync_in ^ pol_q;

  gpio_edge_irq #(.N(N)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sensed_i(sensed),
    .rise_en_i(rise_en), .fall_en_i(fall_en), .clr_i(clr_mask),
    .status_o(status), .edge_o(edge_kind)
  );

  always_comb begin
    case (bus_addr_i)
      OFF_IRQ:  bus_rdata_o = status;
      OFF_EDGE: bus_rdata_o = edge_kind;
      OFF_RISE: bus_rdata_o = rise_en;
      OFF_FALL: bus_rdata_o = fall_en;
      OFF_DATA: bus_rdata_o = (dir_q & data_q) | (~dir_q & sensed);
      OFF_DIR:  bus_rdata_o = dir_q;
      OFF_POL:  bus_rdata_o = pol_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign pin_o    = data_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |status;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         bus_we_i,
  input logic [7:0]   bus_addr_i,
  input logic [N-1:0] bus_wdata_i,
  input logic [N-1:0] pin_o,
  input logic [N-1:0] pin_oe_o,
  input logic         irq_o,
  input logic [N-1:0] rise_en,
  input logic [N-1:0] fall_en
);
  a_r2_dir_to_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 8'h24) |=> pin_oe_o == $past(bus_wdata_i));

  a_r3_set_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 8'h2C) |=> pin_o == ($past(pin_o) | $past(bus_wdata_i)));

  a_r4_clr_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 8'h30) |=> pin_o == ($past(pin_o) & ~$past(bus_wdata_i)));

  a_r5_tog_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == 8'h34) |=> pin_o == ($past(pin_o) ^ $past(bus_wdata_i)));

  a_r9_no_enable_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_en == '0 && fall_en == '0 && !irq_o) |=> !irq_o);
endmodule

bind gpio_bank gpio_bank_chk #(.N(N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o),
  .rise_en(rise_en), .fall_en(fall_en)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  localparam int N = 24;
  logic clk = 1'b0, rst_ni = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  gpio_bank #(.N(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #0.5 d = bus_rdata;
  endtask

  task automatic set_pin(input int b, input logic v);
    @(negedge clk);
    pin_in[b] = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    check("R1 pin_o", 32'(pin_out), 0);
    check("R1 pin_oe_o", 32'(pin_oe), 0);
    check("R1 irq_o", 32'(irq), 0);
    rd(8'h00, d); check("R1 status", 32'(d), 0);
    rd(8'h24, d); check("R1 dir", 32'(d), 0);
  endtask

  task automatic t_data_dir();
    wr(8'h20, 24'hA5_0F3C);
    check("R2 pin_o", 32'(pin_out), 32'hA5_0F3C);
    wr(8'h24, 24'hFF_FFFF);
    check("R2 pin_oe_o", 32'(pin_oe), 32'hFF_FFFF);
  endtask

  task automatic t_atomic();
    logic [N-1:0] d;
    wr(8'h2C, 24'h00_00C3);
    check("R3 set", 32'(pin_out), 32'hA5_0FFF);
    rd(8'h2C, d); check("R3 set reads 0", 32'(d), 0);
    wr(8'h30, 24'hA0_0001);
    check("R4 clear", 32'(pin_out), 32'h05_0FFE);
    rd(8'h30, d); check("R3 clear reads 0", 32'(d), 0);
    wr(8'h34, 24'hFF_0000);
    check("R5 toggle", 32'(pin_out), 32'hFA_0FFE);
    rd(8'h34, d); check("R3 toggle reads 0", 32'(d), 0);
  endtask

  task automatic t_input_read();
    logic [N-1:0] d;
    wr(8'h24, 24'hFF_0000);      // high byte outputs, rest inputs
    wr(8'h28, 24'h00_0100);      // invert pin 8
    @(negedge clk); pin_in = 24'h00_0012;
    repeat (3) @(posedge clk);
    rd(8'h20, d); check("R6 data read", 32'(d), 32'hFA_0112);
    @(negedge clk); pin_in = '0;
    repeat (3) @(posedge clk);
    wr(8'h28, '0);
    wr(8'h24, '0);
  endtask

  task automatic t_rise();
    logic [N-1:0] d;
    wr(8'h08, 24'h00_0008);
    set_pin(3, 1'b1);
    check("R7 irq_o after rise", 32'(irq), 1);
    rd(8'h00, d); check("R7 status", 32'(d), 32'h8);
    rd(8'h04, d); check("R7 edge bit", 32'(d), 32'h8);
  endtask

  task automatic t_masked();
    logic [N-1:0] d;
    wr(8'h00, 24'hFF_FFFF);
    set_pin(7, 1'b1);            // pin 7 has no rising enable
    check("R9 irq_o", 32'(irq), 0);
    rd(8'h00, d); check("R9 status", 32'(d), 0);
    rd(8'h04, d); check("R9 edge", 32'(d), 32'h8);
  endtask

  task automatic t_fall();
    logic [N-1:0] d;
    wr(8'h0C, 24'h00_0088);
    set_pin(3, 1'b0);
    check("R8 irq_o after fall", 32'(irq), 1);
    rd(8'h00, d); check("R8 status", 32'(d), 32'h8);
    rd(8'h04, d); check("R8 edge bit cleared", 32'(d), 0);
    set_pin(7, 1'b0);
    rd(8'h00, d); check("R8 status pin7", 32'(d), 32'h88);
  endtask

  task automatic t_w1c();
    logic [N-1:0] d;
    wr(8'h00, 24'h00_0000);
    rd(8'h00, d); check("R11 zero write keeps", 32'(d), 32'h88);
    wr(8'h00, 24'h00_0008);
    rd(8'h00, d); check("R11 partial clear", 32'(d), 32'h80);
    check("R11 irq_o still set", 32'(irq), 1);
    wr(8'h00, 24'h00_0080);
    check("R11 irq_o cleared", 32'(irq), 0);
  endtask

  task automatic t_polarity();
    logic [N-1:0] d;
    wr(8'h0C, '0);
    wr(8'h28, 24'h00_0020);      // sensed pin 5 goes 0->1 here
    wr(8'h08, '0);
    repeat (3) @(posedge clk);
    wr(8'h00, 24'hFF_FFFF);
    wr(8'h08, 24'h00_0020);
    set_pin(5, 1'b1);            // sensed falls: not enabled
    check("R10 inverted rise ignored", 32'(irq), 0);
    set_pin(5, 1'b0);            // sensed rises
    check("R10 irq_o", 32'(irq), 1);
    rd(8'h04, d); check("R10 edge bit", 32'(d & 24'h20), 32'h20);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_data_dir();
    t_atomic();
    t_input_read();
    t_rise();
    t_masked();
    t_fall();
    t_w1c();
    t_polarity();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule